// File: doc/BRIEF.md
# Reset Cause Latch

This block keeps a record of why the chip most recently restarted. Eight reset origins feed it with one-cycle pulses: the power-on circuit, the chip-wide software reset, the external reset pin, the watchdog, the low-voltage monitor, the brown-out monitor, the processor core's system-reset request and the CPU-only software reset. Each origin sets a sticky flag in a single 32-bit cause register. Boot code reads this register after restart to learn which reset happened.

The register lives at byte offset 0x4 of the owning register block. The flag flops sit on the power-on-only reset domain, so the resets they record do not wipe them. Software clears a flag by writing 1 to its bit. A write of 0 leaves the flag as it is. If a new event and a clearing write hit the same bit in the same cycle, the event wins, so no reset can go unrecorded.

Top module: `rst_cause_latch`

## Requirements
- R1: When the power-on-only reset `por_rst_n` is released, the cause register reads 0x0000_0001: only bit 0 is set.
- R2: A pulse on `src_chip_sw` sets bit 0, the same bit that power-on sets.
- R3: Bit positions: a pulse on `src_pin` sets bit 1, `src_wdog` sets bit 2, `src_lowv` sets bit 3 and `src_brown` sets bit 4.
- R4: A pulse on `src_core_req` sets bit 5. A pulse on `src_cpu_sw` sets bit 7.
- R5: A write to offset 0x4 clears every flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R6: If a set pulse and a write of 1 reach the same flag in the same cycle, the flag is 1 afterwards.
- R7: Bit 6 and bits 31:8 always read 0. No write and no event changes them.
- R8: A set flag stays set, through later events on other sources, until a write of 1 clears it.
- R9: A write to any other offset changes no flag. A read at any offset other than 0x4 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_rst_n | input | 1 | Power-on-only asynchronous reset, active low |
| src_chip_sw | input | 1 | Chip-wide software reset event pulse |
| src_pin | input | 1 | External reset pin event pulse |
| src_wdog | input | 1 | Watchdog reset event pulse |
| src_lowv | input | 1 | Low-voltage reset event pulse |
| src_brown | input | 1 | Brown-out reset event pulse |
| src_core_req | input | 1 | Core system-reset request event pulse |
| src_cpu_sw | input | 1 | CPU-only software reset event pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data: 1 bits clear flags |
| bus_rdata | output | 32 | Read data for `bus_addr` |

## Verification
Single pulses on each source, checked one at a time, tell the bit positions apart. This shows that the two sources that share bit 0 land on the same bit and that no source reaches bit 6. Writes with all ones, with all zeros and with mixed masks show that a clear is selective and that writes do not reach the unused bits. The bench also pulses a source while writing 1 to the same bit, which separates set-wins from clear-wins. A random phase with a fixed seed mixes concurrent events, writes at the right and wrong offsets, and reads at other offsets. This exposes any cross-talk between flags or any sensitivity to the address.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

  localparam int unsigned REG_W   = 32;
  localparam int unsigned NUM_SRC = 7;

  // Bit positions that boot software decodes.
  localparam int unsigned POS_POWER = 0;
  localparam int unsigned POS_PIN   = 1;
  localparam int unsigned POS_WDOG  = 2;
  localparam int unsigned POS_LOWV  = 3;
  localparam int unsigned POS_BROWN = 4;
  localparam int unsigned POS_CORE  = 5;
  localparam int unsigned POS_CPU   = 7;

  localparam logic [REG_W-1:0] IMPL_MASK = REG_W'((1 << POS_POWER) | (1 << POS_PIN) |
    (1 << POS_WDOG) | (1 << POS_LOWV) | (1 << POS_BROWN) | (1 << POS_CORE) | (1 << POS_CPU));

  localparam logic [REG_W-1:0] COLD_VALUE = REG_W'(1 << POS_POWER);

  typedef struct packed {
    logic chip_sw;
    logic pin;
    logic wdog;
    logic lowv;
    logic brown;
    logic core_req;
    logic cpu_sw;
  } cause_src_t;

  // Turns the event pulses into a register-wide set vector.
  function automatic logic [REG_W-1:0] cause_set_vec(input cause_src_t s);
    logic [REG_W-1:0] v;
    v = '0;
    v[POS_POWER] = s.chip_sw;
    v[POS_PIN]   = s.pin;
    v[POS_WDOG]  = s.wdog;
    v[POS_LOWV]  = s.lowv;
    v[POS_BROWN] = s.brown;
    v[POS_CORE]  = s.core_req;
    v[POS_CPU]   = s.cpu_sw;
    return v;
  endfunction

  // Next state of one sticky flag: an event beats a clear.
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/rst_cause_src_map.sv
module rst_cause_src_map
  import rst_cause_pkg::*;
(
  input  cause_src_t       src,
  output logic [REG_W-1:0] set_vec
);

  always_comb set_vec = cause_set_vec(src);

  // R2: the chip-wide software reset lands on the power-on bit.
  always_comb begin
    if (src.chip_sw) begin
      a_chip_sw_map_r2: assert (set_vec[POS_POWER]);
    end
  end

endmodule

// File: rtl/rst_cause_flag_bank.sv
module rst_cause_flag_bank
  import rst_cause_pkg::*;
#(
  parameter int unsigned          WIDTH = REG_W,
  parameter logic [WIDTH-1:0]     MASK  = IMPL_MASK,
  parameter logic [WIDTH-1:0]     COLD  = COLD_VALUE
) (
  input  logic             clk,
  input  logic             por_rst_n,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] flags
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (MASK[i]) begin : g_impl
      logic q;
      always_ff @(posedge clk or negedge por_rst_n) begin
        if (!por_rst_n) q <= COLD[i];
        else            q <= flag_next(q, set_vec[i], clr_vec[i]);
      end
      assign flags[i] = q;

      p_set_wins_r6: assert property (@(posedge clk) disable iff (!por_rst_n)
        set_vec[i] |=> flags[i]);
      p_clear_r5: assert property (@(posedge clk) disable iff (!por_rst_n)
        (clr_vec[i] && !set_vec[i]) |=> !flags[i]);
      p_sticky_r8: assert property (@(posedge clk) disable iff (!por_rst_n)
        (flags[i] && !clr_vec[i]) |=> flags[i]);
      p_no_spurious_r8: assert property (@(posedge clk) disable iff (!por_rst_n)
        (!flags[i] && !set_vec[i]) |=> !flags[i]);
    end else begin : g_tied
      assign flags[i] = 1'b0;
    end
  end

endmodule

// File: rtl/rst_cause_latch.sv
module rst_cause_latch
  import rst_cause_pkg::*;
#(
  parameter int unsigned         ADDR_W      = 12,
  parameter logic [ADDR_W-1:0]   CAUSE_OFFS  = ADDR_W'(4)
) (
  input  logic              clk,
  input  logic              por_rst_n,
  input  logic              src_chip_sw,
  input  logic              src_pin,
  input  logic              src_wdog,
  input  logic              src_lowv,
  input  logic              src_brown,
  input  logic              src_core_req,
  input  logic              src_cpu_sw,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata
);

  cause_src_t       src;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] flags;
  logic             hit;
  logic             clr_write;

  assign src = '{chip_sw: src_chip_sw, pin: src_pin, wdog: src_wdog, lowv: src_lowv,
                 brown: src_brown, core_req: src_core_req, cpu_sw: src_cpu_sw};

  assign hit       = (bus_addr == CAUSE_OFFS);
  assign clr_write = bus_wr & hit;
  assign clr_vec   = clr_write ? bus_wdata : '0;

  rst_cause_src_map u_map (
    .src     (src),
    .set_vec (set_vec)
  );

  rst_cause_flag_bank #(
    .WIDTH (REG_W),
    .MASK  (IMPL_MASK),
    .COLD  (COLD_VALUE)
  ) u_bank (
    .clk       (clk),
    .por_rst_n (por_rst_n),
    .set_vec   (set_vec),
    .clr_vec   (clr_vec),
    .flags     (flags)
  );

  assign bus_rdata = hit ? flags : '0;

  p_cold_value_r1: assert property (@(posedge clk)
    $rose(por_rst_n) |-> (flags == COLD_VALUE));

  p_unused_quiet_r7: assert property (@(posedge clk) disable iff (!por_rst_n)
    (flags & ~IMPL_MASK) == '0);

  p_foreign_write_r9: assert property (@(posedge clk) disable iff (!por_rst_n)
    (set_vec == '0 && !clr_write) |=> $stable(flags));

endmodule

// File: tb/rst_cause_latch_bench.sv
module rst_cause_latch_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [11:0] OFFS = 12'h004;
  localparam logic [31:0] LIVE = 32'h0000_00BF;

  logic clk = 1'b0;
  logic por_rst_n = 1'b0;
  logic [6:0] ev;   // {cpu_sw, core_req, brown, lowv, wdog, pin, chip_sw}
  logic bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] model;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_latch u_rst_cause_latch (
    .clk(clk), .por_rst_n(por_rst_n),
    .src_chip_sw(ev[0]), .src_pin(ev[1]), .src_wdog(ev[2]), .src_lowv(ev[3]),
    .src_brown(ev[4]), .src_core_req(ev[5]), .src_cpu_sw(ev[6]),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Event index to register bit: 0,1,2,3,4,5 map straight, index 6 goes to bit 7.
  function automatic logic [31:0] ev_bits(input logic [6:0] e);
    logic [31:0] r = '0;
    for (int k = 0; k < 6; k++) r[k] = e[k];
    r[7] = e[6];
    return r;
  endfunction

  function automatic logic [31:0] predict(input logic [31:0] cur, input logic [6:0] e,
                                          input logic wr, input logic [11:0] a, input logic [31:0] d);
    logic [31:0] clr = (wr && a == OFFS) ? d : 32'h0;
    return ((cur & ~clr) | ev_bits(e)) & LIVE;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Drives one cycle, then reads the register at offset 0x4.
  task automatic step(input string req, input logic [6:0] e, input logic wr,
                      input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    ev = e; bus_wr = wr; bus_addr = a; bus_wdata = d;
    model = predict(model, e, wr, a, d);
    @(negedge clk);
    ev = '0; bus_wr = 1'b0; bus_addr = OFFS; bus_wdata = '0;
    #1;
    check(req, bus_rdata, model);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got hang expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    ev = '0; bus_wr = 1'b0; bus_addr = OFFS; bus_wdata = '0;
    model = 32'h1;
    repeat (3) @(negedge clk);
    por_rst_n = 1'b1;
    #1;
    check("R1 cold value", bus_rdata, 32'h0000_0001);

    step("R5 clear bit0", 7'h00, 1'b1, OFFS, 32'h1);
    check("R5 cleared to zero", bus_rdata, 32'h0);
    step("R2 chip sw sets bit0", 7'h01, 1'b0, OFFS, 0);
    check("R2 bit0 value", bus_rdata, 32'h1);
    step("R5 clear", 7'h00, 1'b1, OFFS, 32'hFFFF_FFFF);
    for (int k = 1; k < 7; k++) begin
      step((k < 5) ? "R3 single source" : "R4 single source", 7'(1 << k), 1'b0, OFFS, 0);
      check((k < 5) ? "R3 bit position" : "R4 bit position", bus_rdata, ev_bits(7'(1 << k)));
      step("R5 clear all", 7'h00, 1'b1, OFFS, 32'hFFFF_FFFF);
    end
    step("R8 set pin", 7'h02, 1'b0, OFFS, 0);
    step("R8 other sources keep pin", 7'h14, 1'b0, OFFS, 0);
    check("R8 value", bus_rdata, 32'h16);
    step("R5 zero write no effect", 7'h00, 1'b1, OFFS, 32'h0);
    check("R5 zero write value", bus_rdata, 32'h16);
    step("R5 selective clear", 7'h00, 1'b1, OFFS, 32'h4);
    check("R5 selective value", bus_rdata, 32'h12);
    step("R6 set beats clear", 7'h02, 1'b1, OFFS, 32'h2);
    check("R6 value", bus_rdata, 32'h12);
    step("R9 write elsewhere", 7'h00, 1'b1, 12'h008, 32'hFFFF_FFFF);
    check("R9 value", bus_rdata, 32'h12);
    @(negedge clk); bus_addr = 12'h000; #1;
    check("R9 read elsewhere", bus_rdata, 32'h0);
    bus_addr = OFFS;
    step("R7 clear all", 7'h00, 1'b1, OFFS, 32'hFFFF_FFFF);
    step("R7 all sources", 7'h7F, 1'b0, OFFS, 0);
    check("R7 bit6 and upper zero", bus_rdata & ~LIVE, 32'h0);

    for (int n = 0; n < 400; n++) begin
      logic [6:0] e = 7'($urandom) & 7'($urandom) & 7'($urandom);
      logic wr = ($urandom % 3) == 0;
      logic [11:0] a = ($urandom % 4 == 0) ? 12'(($urandom % 16) * 4) : OFFS;
      step("R8 random mix", e, wr, a, $urandom);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule